// File: doc/BRIEF.md
# Segment Address Translator

This block turns a segmented virtual address into a flat linear address. A request carries a 16-bit selector and a 32-bit offset. The selector names one 8-byte descriptor in either the global or the local descriptor table. The base address of each table comes from its own input.

On a miss, the block computes where the descriptor sits in memory. It reads the descriptor as two 32-bit words over a simple request/valid read port. It then stores base, limit and access rights in a one-entry descriptor cache.

The linear address is the segment base plus the offset. The offset is checked against the segment limit. When paging is off, the linear address is also given as the physical address.

A later request with the same selector is served from the cache with no memory traffic. It completes one cycle after it is accepted.

Top module: `seg_xlate`

## Requirements
- R1: After reset `busy_o`, `done_o`, `fault_o`, `phys_valid_o` and `mem_req_o` are low, and the descriptor cache is empty. The first request always fetches, even for selector 0.
- R2: Selector layout: bits [1:0] are the requested level, returned on `rpl_o`. Bit 2 picks the table: 1 selects `ldt_base_i` and 0 selects `gdt_base_i`. Bits [15:3] are the descriptor index (0 to 8191).
- R3: The descriptor address is table base + index × 8, modulo 2^32. A fetch reads that address and then that address + 4. `mem_req_o` stays high with `mem_addr_o` unchanged until `mem_rvalid_i` is seen.
- R4: Descriptor layout: the word at the lower address is the 32-bit segment base. In the word at +4, bits [19:0] are the limit and bits [31:20] are the access rights, returned on `rights_o`.
- R5: `lin_addr_o` = base + offset, modulo 2^32. `done_o` pulses for one cycle, in the cycle after the second read word is accepted.
- R6: An offset greater than the limit raises `fault_o` together with `done_o`, forces `lin_addr_o` to 0 and keeps `phys_valid_o` low. An offset equal to the limit is legal.
- R7: With `paging_en_i` low at completion, `phys_addr_o` equals `lin_addr_o` and `phys_valid_o` pulses with `done_o`. With it high, `phys_valid_o` stays low and `phys_addr_o` is 0.
- R8: A request whose selector equals the last fetched selector issues no memory read. Its `done_o` appears in the cycle after the request.
- R9: A request asserted while `busy_o` is high is ignored. It changes neither the pending result nor the cache, and it produces no extra `done_o`.
- R10: `busy_o` is high from the cycle after a missing request is accepted until the cycle that shows `done_o`, and is low whenever `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Translation request, sampled while idle |
| sel_i | input | 16 | Segment selector |
| off_i | input | 32 | Offset within segment |
| gdt_base_i | input | 32 | Global table base address |
| ldt_base_i | input | 32 | Local table base address |
| paging_en_i | input | 1 | Paging enabled; suppresses physical output |
| busy_o | output | 1 | Descriptor fetch in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Limit violation, pulses with done_o |
| lin_addr_o | output | 32 | Linear address of last completion |
| phys_addr_o | output | 32 | Physical address when paging is off |
| phys_valid_o | output | 1 | Physical address valid, pulses with done_o |
| rpl_o | output | 2 | Requested level of last completion |
| rights_o | output | 12 | Access rights of the used descriptor |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory read address |
| mem_rdata_i | input | 32 | Memory read data |
| mem_rvalid_i | input | 1 | Read data valid, accepts the request |

## Verification
A stale or wrongly loaded cache register shows up at the ports in two ways. A repeated selector may produce a memory read where none is due, or a wrong base, limit or rights value, at the very next `done_o`. A wrongly added base shows the same way. A stuck fetch state keeps `busy_o` high and `done_o` silent. A bad address or read order shows at `mem_addr_o` during the first fetch. Completion latency is checked per request, so a one-cycle slip on a cache hit is caught at once.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned SEL_W    = 16;
  localparam int unsigned LIMIT_W  = 20;
  localparam int unsigned RIGHTS_W = 12;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2
  } fetch_st_e;
endpackage

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int unsigned SEL_W  = 16,
  parameter int unsigned ADDR_W = 32
) (
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [ADDR_W-1:0] gdt_base_i,
  input  logic [ADDR_W-1:0] ldt_base_i,
  output logic [ADDR_W-1:0] desc_addr_o
);
  localparam int unsigned IDX_LSB  = 3;
  localparam int unsigned IDX_W    = SEL_W - IDX_LSB;
  localparam int unsigned DESC_SH  = 3; // 8-byte descriptors

  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] tbl_base;

  assign idx         = sel_i[SEL_W-1:IDX_LSB];
  assign tbl_base    = sel_i[2] ? ldt_base_i : gdt_base_i;
  assign desc_addr_o = tbl_base + (ADDR_W'(idx) << DESC_SH);
endmodule

// File: rtl/seg_desc_cache.sv
module seg_desc_cache #(
  parameter int unsigned SEL_W    = 16,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned LIMIT_W  = 20,
  parameter int unsigned RIGHTS_W = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic                load_i,
  input  logic [SEL_W-1:0]    load_sel_i,
  input  logic [ADDR_W-1:0]   load_base_i,
  input  logic [LIMIT_W-1:0]  load_limit_i,
  input  logic [RIGHTS_W-1:0] load_rights_i,
  output logic                hit_o,
  output logic [ADDR_W-1:0]   base_o,
  output logic [LIMIT_W-1:0]  limit_o,
  output logic [RIGHTS_W-1:0] rights_o
);
  logic             valid_q;
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      sel_q    <= '0;
      base_o   <= '0;
      limit_o  <= '0;
      rights_o <= '0;
    end else if (load_i) begin
      valid_q  <= 1'b1;
      sel_q    <= load_sel_i;
      base_o   <= load_base_i;
      limit_o  <= load_limit_i;
      rights_o <= load_rights_i;
    end
  end

  assign hit_o = valid_q && (sel_q == sel_i);
endmodule

// File: rtl/seg_xlate_calc.sv
module seg_xlate_calc #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned LIMIT_W = 20
) (
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [LIMIT_W-1:0] limit_i,
  input  logic [ADDR_W-1:0]  off_i,
  input  logic               paging_en_i,
  output logic [ADDR_W-1:0]  lin_o,
  output logic               fault_o,
  output logic [ADDR_W-1:0]  phys_o,
  output logic               phys_valid_o
);
  assign fault_o      = off_i > ADDR_W'(limit_i);
  assign lin_o        = fault_o ? '0 : base_i + off_i;
  assign phys_valid_o = !fault_o && !paging_en_i;
  assign phys_o       = phys_valid_o ? lin_o : '0;
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int unsigned AW  = ADDR_W,
  parameter int unsigned SW  = SEL_W,
  parameter int unsigned LW  = LIMIT_W,
  parameter int unsigned RW  = RIGHTS_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [SW-1:0] sel_i,
  input  logic [AW-1:0] off_i,
  input  logic [AW-1:0] gdt_base_i,
  input  logic [AW-1:0] ldt_base_i,
  input  logic          paging_en_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          fault_o,
  output logic [AW-1:0] lin_addr_o,
  output logic [AW-1:0] phys_addr_o,
  output logic          phys_valid_o,
  output logic [1:0]    rpl_o,
  output logic [RW-1:0] rights_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [AW-1:0] mem_rdata_i,
  input  logic          mem_rvalid_i
);
  localparam int unsigned HI_OFS = 4;

  fetch_st_e     st_q;
  logic [SW-1:0] sel_q;
  logic [AW-1:0] off_q;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] lo_q;

  logic [AW-1:0] desc_addr;
  logic          c_hit;
  logic [AW-1:0] c_base;
  logic [LW-1:0] c_limit;
  logic [RW-1:0] c_rights;

  logic          idle_hit;
  logic          hi_done;
  logic          load;

  logic [AW-1:0] u_base;
  logic [LW-1:0] u_limit;
  logic [RW-1:0] u_rights;
  logic [AW-1:0] u_off;
  logic [SW-1:0] u_sel;
  logic [AW-1:0] r_lin;
  logic [AW-1:0] r_phys;
  logic          r_fault;
  logic          r_pv;

  seg_addr_gen #(.SEL_W(SW), .ADDR_W(AW)) addr_gen_i (
    .sel_i       (sel_i),
    .gdt_base_i  (gdt_base_i),
    .ldt_base_i  (ldt_base_i),
    .desc_addr_o (desc_addr)
  );

  assign idle_hit = (st_q == ST_IDLE) && req_i && c_hit;
  assign hi_done  = (st_q == ST_HI) && mem_rvalid_i;
  assign load     = hi_done;

  seg_desc_cache #(.SEL_W(SW), .ADDR_W(AW), .LIMIT_W(LW), .RIGHTS_W(RW)) cache_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sel_i         (sel_i),
    .load_i        (load),
    .load_sel_i    (sel_q),
    .load_base_i   (lo_q),
    .load_limit_i  (mem_rdata_i[LW-1:0]),
    .load_rights_i (mem_rdata_i[LW+RW-1:LW]),
    .hit_o         (c_hit),
    .base_o        (c_base),
    .limit_o       (c_limit),
    .rights_o      (c_rights)
  );

  // result source: fresh descriptor on fetch end, cache on hit
  always_comb begin
    if (st_q == ST_HI) begin
      u_base   = lo_q;
      u_limit  = mem_rdata_i[LW-1:0];
      u_rights = mem_rdata_i[LW+RW-1:LW];
      u_off    = off_q;
      u_sel    = sel_q;
    end else begin
      u_base   = c_base;
      u_limit  = c_limit;
      u_rights = c_rights;
      u_off    = off_i;
      u_sel    = sel_i;
    end
  end

  seg_xlate_calc #(.ADDR_W(AW), .LIMIT_W(LW)) calc_i (
    .base_i       (u_base),
    .limit_i      (u_limit),
    .off_i        (u_off),
    .paging_en_i  (paging_en_i),
    .lin_o        (r_lin),
    .fault_o      (r_fault),
    .phys_o       (r_phys),
    .phys_valid_o (r_pv)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sel_q  <= '0;
      off_q  <= '0;
      addr_q <= '0;
      lo_q   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_i && !c_hit) begin
          sel_q  <= sel_i;
          off_q  <= off_i;
          addr_q <= desc_addr;
          st_q   <= ST_LO;
        end
        ST_LO: if (mem_rvalid_i) begin
          lo_q <= mem_rdata_i;
          st_q <= ST_HI;
        end
        ST_HI: if (mem_rvalid_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o       <= 1'b0;
      fault_o      <= 1'b0;
      phys_valid_o <= 1'b0;
      lin_addr_o   <= '0;
      phys_addr_o  <= '0;
      rpl_o        <= '0;
      rights_o     <= '0;
    end else begin
      done_o       <= idle_hit || hi_done;
      fault_o      <= (idle_hit || hi_done) && r_fault;
      phys_valid_o <= (idle_hit || hi_done) && r_pv;
      if (idle_hit || hi_done) begin
        lin_addr_o  <= r_lin;
        phys_addr_o <= r_phys;
        rpl_o       <= u_sel[1:0];
        rights_o    <= u_rights;
      end
    end
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign mem_req_o  = busy_o;
  assign mem_addr_o = (st_q == ST_HI) ? addr_q + AW'(HI_OFS) : addr_q;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic          fault_o,
  input logic [AW-1:0] lin_addr_o,
  input logic [AW-1:0] phys_addr_o,
  input logic          phys_valid_o,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_rvalid_i
);
  assert_fetch_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  assert_addr_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  assert_fault_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (done_o && lin_addr_o == '0 && !phys_valid_o));

  assert_phys_match_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phys_valid_o |-> (done_o && phys_addr_o == lin_addr_o));

  assert_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

bind seg_xlate seg_xlate_chk #(.AW(AW)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .fault_o      (fault_o),
  .lin_addr_o   (lin_addr_o),
  .phys_addr_o  (phys_addr_o),
  .phys_valid_o (phys_valid_o),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_rvalid_i (mem_rvalid_i)
);

// File: tb/seg_xlate_tb_top.sv
module seg_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [15:0] sel = '0;
  logic [31:0] off = '0;
  logic [31:0] gdt_base = 32'h0000_1000;
  logic [31:0] ldt_base = 32'h0000_4000;
  logic        pg = 1'b0;
  logic        busy_o, done_o, fault_o, phys_valid_o, mem_req_o;
  logic [31:0] lin_addr_o, phys_addr_o, mem_addr_o;
  logic [1:0]  rpl_o;
  logic [11:0] rights_o;
  logic [31:0] mem_rdata = '0;
  logic        mem_rvalid = 1'b0;

  always #10 clk = ~clk;

  seg_xlate dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .sel_i(sel), .off_i(off),
    .gdt_base_i(gdt_base), .ldt_base_i(ldt_base), .paging_en_i(pg),
    .busy_o(busy_o), .done_o(done_o), .fault_o(fault_o),
    .lin_addr_o(lin_addr_o), .phys_addr_o(phys_addr_o),
    .phys_valid_o(phys_valid_o), .rpl_o(rpl_o), .rights_o(rights_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rdata_i(mem_rdata), .mem_rvalid_i(mem_rvalid)
  );

  typedef struct {
    logic [31:0] lin;
    logic        flt;
    logic [31:0] phys;
    logic        pv;
    logic [1:0]  rpl;
    logic [11:0] rights;
    int          reads;
    logic [31:0] addr0;
    bit          hit;
    int          req_cyc;
  } exp_t;

  exp_t        sb_q[$];
  logic [31:0] mem [logic [31:0]];
  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;
  int          lat = 1;
  int          wait_cnt = 0;
  int          reads = 0;
  logic [31:0] addr0 = '0;
  logic [31:0] addr1 = '0;
  int          done_cnt = 0;
  bit          cvalid = 1'b0;
  logic [15:0] csel = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string rq, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic set_desc(input logic [31:0] tb, input int idx, input logic [31:0] base,
                          input logic [19:0] lim, input logic [11:0] rt);
    logic [31:0] a;
    a = tb + 32'(idx) * 8;
    mem[a]     = base;
    mem[a + 4] = {rt, lim};
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // memory model: acknowledges after lat idle cycles
  always @(negedge clk) begin
    if (mem_rvalid) mem_rvalid = 1'b0;
    else if (mem_req_o) begin
      if (wait_cnt >= lat) begin
        mem_rvalid = 1'b1;
        mem_rdata  = rd(mem_addr_o);
        if (reads == 0) addr0 = mem_addr_o;
        else addr1 = mem_addr_o;
        reads++;
        wait_cnt = 0;
      end else wait_cnt++;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 unexpected done actual=1 expected=0");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk("R5", "lin_addr", lin_addr_o, e.lin);
        chk("R6", "fault", 32'(fault_o), 32'(e.flt));
        chk("R7", "phys_addr", phys_addr_o, e.phys);
        chk("R7", "phys_valid", 32'(phys_valid_o), 32'(e.pv));
        chk("R2", "rpl", 32'(rpl_o), 32'(e.rpl));
        chk("R4", "rights", 32'(rights_o), 32'(e.rights));
        chk("R8", "reads", 32'(reads), 32'(e.reads));
        chk("R10", "busy_at_done", 32'(busy_o), 32'h0);
        if (e.hit) chk("R8", "hit_latency", 32'(cyc - e.req_cyc), 32'd1);
        else begin
          chk("R3", "first_addr", addr0, e.addr0);
          chk("R3", "second_addr", addr1, e.addr0 + 32'd4);
        end
      end
      done_cnt++;
    end
  end

  task automatic xlate(input logic [15:0] s, input logic [31:0] o, input bit p,
                       input bit intr = 1'b0);
    exp_t        e;
    logic [31:0] a, w0, w1;
    int          tgt;
    a  = (s[2] ? ldt_base : gdt_base) + {16'h0, s[15:3], 3'b000};
    w0 = rd(a);
    w1 = rd(a + 4);
    e.hit    = cvalid && (csel == s);
    e.flt    = o > {12'h0, w1[19:0]};
    e.lin    = e.flt ? 32'h0 : w0 + o;
    e.pv     = !e.flt && !p;
    e.phys   = e.pv ? e.lin : 32'h0;
    e.rpl    = s[1:0];
    e.rights = w1[31:20];
    e.reads  = e.hit ? 0 : 2;
    e.addr0  = a;
    tgt = done_cnt + 1;
    @(negedge clk);
    reads = 0;
    req = 1'b1; sel = s; off = o; pg = p;
    e.req_cyc = cyc;
    sb_q.push_back(e);
    @(negedge clk);
    req = 1'b0;
    if (!e.hit) chk("R10", "busy_after_req", 32'(busy_o), 32'h1);
    if (intr) begin
      @(negedge clk);
      chk("R9", "busy_during_intr", 32'(busy_o), 32'h1);
      req = 1'b1; sel = 16'h002F; off = 32'h0;
      @(negedge clk);
      req = 1'b0; sel = s; off = o;
    end
    wait (done_cnt >= tgt);
    @(negedge clk);
    cvalid = 1'b1;
    csel   = s;
  endtask

  initial begin
    set_desc(gdt_base, 0,    32'h0050_0000, 20'h00FFF, 12'h09A);
    set_desc(gdt_base, 3,    32'h0003_0000, 20'hFFFFF, 12'h092);
    set_desc(gdt_base, 5,    32'h0A00_0000, 20'hFFFFF, 12'h09B);
    set_desc(gdt_base, 8191, 32'hFFFF_F000, 20'h01FFF, 12'h093);
    set_desc(ldt_base, 2,    32'h0010_0000, 20'h00010, 12'h0F3);
    set_desc(ldt_base, 5,    32'h1234_0000, 20'h00100, 12'h0F2);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy", 32'(busy_o), 32'h0);
    chk("R1", "done", 32'(done_o), 32'h0);
    chk("R1", "fault", 32'(fault_o), 32'h0);
    chk("R1", "phys_valid", 32'(phys_valid_o), 32'h0);
    chk("R1", "mem_req", 32'(mem_req_o), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    lat = 1;
    xlate(16'h0000, 32'h10, 1'b0);          // R1 empty cache: selector 0 must fetch
    xlate(16'h0018, 32'h2000, 1'b0);        // R5 base 30000h + 2000h
    xlate(16'h0018, 32'h44, 1'b0);          // R8 hit
    lat = 2;
    xlate(16'h002F, 32'h100, 1'b1);         // R2 local table, rpl 3; R6 offset == limit; R7 paging on
    xlate(16'h002F, 32'h101, 1'b0);         // R6 hit with offset > limit
    xlate(16'h0028, 32'h8, 1'b0);           // R2 same index, global table
    lat = 3;
    xlate(16'h0015, 32'h11, 1'b0);          // R6 miss with fault, rpl 1
    xlate(16'hFFF8, 32'h1800, 1'b0);        // R3 max index; R5 wraparound
    lat = 0;
    xlate(16'h0018, 32'h8, 1'b0, 1'b1);     // R9 request while busy ignored
    xlate(16'h0018, 32'hC, 1'b0);           // R9 cache still holds the first selector
    repeat (4) @(negedge clk);
    chk("R9", "queue_empty", 32'(sb_q.size()), 32'h0);
    finish_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_up();
  end
endmodule